// File: doc/BRIEF.md
# Shared Free-Running Ring Time Stamper

This block is the digital back end of a time-to-digital converter whose time base is a ring oscillator built from NSTG inverting stages. The ring is never stopped or restarted. On every clock edge the block reads the ring's stage outputs and decodes them into a fine phase. It also keeps a coarse counter of completed ring revolutions. Together the two form a running timestamp in units of one stage delay.

Several conversion channels read the same ring in parallel. Each channel latches a timestamp when its reference strobe arrives and another when its signal strobe arrives. The channel result is the difference of the two, taken modulo the configured range. Because both events are measured against the same ring, slow drift of the ring rate cancels. A run-time setting picks the coarse width: each extra bit doubles both the range and the allowed interval. In gang mode all channels measure together, and their codes are summed into one result with finer effective resolution.

The model assumes that the ring advances by fewer than 2·NSTG stage delays between two clock edges.

Top module: `ring_tdc_backend`

## Requirements
- R1: After reset, all code outputs, all valid flags, the sum output and its flag are zero.
- R2: For ring phase k (0 ≤ k < 2·NSTG), tap bit i is 1 when i < k for k ≤ NSTG, and 1 when i ≥ k−NSTG for k > NSTG. Phase 0 is all zeros. Each phase decodes to the fine value k.
- R3: The timestamp equals revolutions × 2·NSTG + phase, where revolutions counts each clock edge whose decoded phase is lower than the phase at the previous edge. The revolution count starts at zero at reset.
- R4: A signal strobe on an armed channel produces a code equal to (signal timestamp − reference timestamp) mod (2·NSTG · 2^w). The code appears with a one-cycle valid pulse after the edge that sampled the strobe, and the channel is then disarmed.
- R5: An event sampled on the same edge at which the ring passes phase 0 uses the revolution count after that increment.
- R6: The coarse width w is CW_MIN + cw_sel, clamped to CW_MAX. It is applied at the edge that sees the signal strobe.
- R7: An interval during which the revolution counter rolls over still gives the correct positive code modulo the range.
- R8: A signal strobe on a channel that is not armed produces no valid pulse and leaves the channel unarmed.
- R9: A reference strobe on an armed channel replaces the stored reference timestamp. When both strobes arrive on the same edge, the signal is measured against the older reference and the new reference then arms the channel.
- R10: A snapshot with two adjacent tap bits swapped, which keeps the number of ones and the value of tap bit 0, decodes to the same phase. No flag is raised.
- R11: With gang high, per-channel valid pulses are suppressed. Once every channel has completed a conversion since the last sum, sum_vld pulses one cycle later with the sum of all channel codes.
- R12: Channels convert independently and concurrently, including strobes on several channels at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_taps | input | NSTG | Ring stage outputs, sampled each edge |
| ref_ev | input | NCH | Per-channel reference strobe |
| sig_ev | input | NCH | Per-channel signal strobe |
| cw_sel | input | SELW | Coarse width selector |
| gang | input | 1 | Combine all channels into one summed result |
| code | output | NCH·CODEW | Per-channel interval codes, channel c at bits c·CODEW |
| code_vld | output | NCH | Per-channel one-cycle valid |
| sum_code | output | SUMW | Sum of all channel codes in gang mode |
| sum_vld | output | 1 | One-cycle valid for sum_code |

## Verification
A unit-step ring walk through every phase separates decode errors from counter errors. Steps that cross phase 0 exactly at a strobe isolate the wrap correction. Long intervals of large steps, swept over every width setting, expose modulo and rollover mistakes. Random ring steps, sparse strobes, swapped-bit snapshots and gang segments mix all paths, while directed unarmed, double-reference and simultaneous-strobe cases pin down the arming rules.

// File: rtl/ring_tdc_backend.sv
module ring_tdc_backend #(
  parameter int NSTG   = 5,
  parameter int NCH    = 3,
  parameter int CW_MIN = 4,
  parameter int CW_MAX = 8,
  localparam int NPH   = 2 * NSTG,
  localparam int FW    = $clog2(NPH),
  localparam int CODEW = CW_MAX + FW,
  localparam int SUMW  = CODEW + $clog2(NCH),
  localparam int SELW  = $clog2(CW_MAX - CW_MIN + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSTG-1:0]        ring_taps,
  input  logic [NCH-1:0]         ref_ev,
  input  logic [NCH-1:0]         sig_ev,
  input  logic [SELW-1:0]        cw_sel,
  input  logic                   gang,
  output logic [NCH*CODEW-1:0]   code,
  output logic [NCH-1:0]         code_vld,
  output logic [SUMW-1:0]        sum_code,
  output logic                   sum_vld
);
  localparam int SPAN = CW_MAX - CW_MIN;

  function automatic logic [FW-1:0] ones_of(input logic [NSTG-1:0] v);
    logic [FW-1:0] n;
    n = '0;
    for (int i = 0; i < NSTG; i++) n = n + FW'(v[i]);
    return n;
  endfunction

  logic [FW-1:0]     ones, ph, ph_q;
  logic              wrap;
  logic [CW_MAX-1:0] cnt_q, cnt_now, cmask;
  logic [NCH-1:0]    done_v, fresh_q;
  logic [SUMW-1:0]   sum_n;
  int                w;

  assign ones = ones_of(ring_taps);

  always_comb begin
    if (ring_taps[0])   ph = ones;
    else if (ones == 0) ph = '0;
    else                ph = FW'(NPH - int'(ones));
  end

  assign wrap    = ph < ph_q;
  assign cnt_now = cnt_q + CW_MAX'(wrap);

  always_comb begin
    w = (int'(cw_sel) > SPAN) ? CW_MAX : CW_MIN + int'(cw_sel);
    cmask = {CW_MAX{1'b1}} >> (CW_MAX - w);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= '0;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph;
      cnt_q <= cnt_now;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CW_MAX-1:0] rc_q, dc;
    logic [FW-1:0]     rf_q, df;
    logic              arm_q, borrow;
    logic [CODEW-1:0]  cq, cn;

    assign borrow    = ph < rf_q;
    assign dc        = (cnt_now - rc_q - CW_MAX'(borrow)) & cmask;
    assign df        = FW'(int'(ph) + (borrow ? NPH : 0) - int'(rf_q));
    assign cn        = CODEW'(dc) * CODEW'(NPH) + CODEW'(df);
    assign done_v[c] = sig_ev[c] & arm_q;
    assign code[c*CODEW +: CODEW] = cq;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rc_q  <= '0;
        rf_q  <= '0;
        arm_q <= 1'b0;
        cq    <= '0;
      end else begin
        if (done_v[c]) cq <= cn;
        arm_q <= ref_ev[c] | (arm_q & ~sig_ev[c]);
        if (ref_ev[c]) begin
          rc_q <= cnt_now;
          rf_q <= ph;
        end
      end
    end
  end

  always_comb begin
    sum_n = '0;
    for (int c = 0; c < NCH; c++) sum_n = sum_n + SUMW'(code[c*CODEW +: CODEW]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_vld <= '0;
      fresh_q  <= '0;
      sum_vld  <= 1'b0;
      sum_code <= '0;
    end else begin
      code_vld <= done_v & {NCH{~gang}};
      sum_vld  <= gang & (&fresh_q);
      if (gang & (&fresh_q)) sum_code <= sum_n;
      if (gang) fresh_q <= ((&fresh_q) ? '0 : fresh_q) | done_v;
      else      fresh_q <= '0;
    end
  end
endmodule

// File: rtl/tdc_chk.sv
module tdc_chk #(
  parameter int NSTG   = 5,
  parameter int NCH    = 3,
  parameter int CW_MAX = 8,
  parameter int FW     = 4,
  parameter int CODEW  = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 gang,
  input logic [NCH-1:0]       code_vld,
  input logic [NCH*CODEW-1:0] code,
  input logic                 sum_vld,
  input logic [FW-1:0]        ph,
  input logic [CW_MAX-1:0]    cnt_q
);
  localparam int NPH = 2 * NSTG;

  a_r2_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, ph} < (FW+1)'(NPH));

  a_r3_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != $past(cnt_q) |-> cnt_q == CW_MAX'($past(cnt_q) + 1'b1));

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sum_vld && (|code_vld)));

  a_r11_sum_needs_gang: assert property (@(posedge clk) disable iff (!rst_n)
    sum_vld |-> $past(gang));

  a_r11_vld_needs_solo: assert property (@(posedge clk) disable iff (!rst_n)
    (|code_vld) |-> !$past(gang));

  for (genvar c = 0; c < NCH; c++) begin : g_rng
    a_r4_code_range: assert property (@(posedge clk) disable iff (!rst_n)
      code_vld[c] |-> {1'b0, code[c*CODEW +: CODEW]} < (CODEW+1)'(NPH << CW_MAX));
  end
endmodule

bind ring_tdc_backend tdc_chk #(
  .NSTG(NSTG), .NCH(NCH), .CW_MAX(CW_MAX), .FW(FW), .CODEW(CODEW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gang(gang), .code_vld(code_vld), .code(code),
  .sum_vld(sum_vld), .ph(ph), .cnt_q(cnt_q)
);

// File: tb/sim_ring_tdc_backend.sv
module sim_ring_tdc_backend;
  localparam int NSTG = 5, NCH = 3, CW_MIN = 4, CW_MAX = 8;
  localparam int NPH = 2 * NSTG;
  localparam int FW = $clog2(NPH);
  localparam int CODEW = CW_MAX + FW;
  localparam int SUMW = CODEW + $clog2(NCH);
  localparam int SELW = $clog2(CW_MAX - CW_MIN + 1);

  logic clk = 0, rst_n = 0, gang = 0;
  logic [NSTG-1:0] ring_taps = '0;
  logic [NCH-1:0] ref_ev = '0, sig_ev = '0;
  logic [SELW-1:0] cw_sel = '0;
  logic [NCH*CODEW-1:0] code;
  logic [NCH-1:0] code_vld;
  logic [SUMW-1:0] sum_code;
  logic sum_vld;

  ring_tdc_backend #(.NSTG(NSTG), .NCH(NCH), .CW_MIN(CW_MIN), .CW_MAX(CW_MAX)) u0 (
    .clk(clk), .rst_n(rst_n), .ring_taps(ring_taps), .ref_ev(ref_ev), .sig_ev(sig_ev),
    .cw_sel(cw_sel), .gang(gang), .code(code), .code_vld(code_vld),
    .sum_code(sum_code), .sum_vld(sum_vld));

  always #4 clk = ~clk;

  int nchk = 0, nbad = 0, P = 0;
  string tag = "R1";
  bit cfg_g = 0;
  int cfg_sel = 0;
  bit [NCH-1:0] m_arm = '0, m_fresh = '0, e_vld = '0;
  int m_ref[NCH], m_code[NCH];
  bit e_svld = 0;
  int e_sum = 0;
  bit ended = 0;

  task automatic chk(input string t, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s act=%0d exp=%0d", t, act, exp);
    end
  endtask

  function automatic logic [NSTG-1:0] mk(input int k, input bit bub);
    logic [NSTG-1:0] v;
    for (int i = 0; i < NSTG; i++) v[i] = (k <= NSTG) ? (i < k) : (i >= k - NSTG);
    if (bub && k >= 2 && k <= NSTG - 1) begin v[k-1] = ~v[k-1]; v[k] = ~v[k]; end
    if (bub && k >= NSTG + 2) begin v[k-NSTG] = ~v[k-NSTG]; v[k-NSTG-1] = ~v[k-NSTG-1]; end
    return v;
  endfunction

  function automatic int range_now();
    int w;
    w = (cfg_sel > CW_MAX - CW_MIN) ? CW_MAX : CW_MIN + cfg_sel;
    return NPH << w;
  endfunction

  task automatic check_out();
    for (int c = 0; c < NCH; c++) begin
      chk(tag, int'(code_vld[c]), int'(e_vld[c]));
      if (e_vld[c]) chk(tag, int'(code[c*CODEW +: CODEW]), m_code[c]);
    end
    chk(tag, int'(sum_vld), int'(e_svld));
    if (e_svld) chk(tag, int'(sum_code), e_sum);
  endtask

  task automatic cyc(input int step, input bit [NCH-1:0] r, input bit [NCH-1:0] s, input bit bub);
    bit [NCH-1:0] done;
    @(negedge clk);
    check_out();
    P += step;
    ring_taps = mk(P % NPH, bub);
    ref_ev = r; sig_ev = s; gang = cfg_g; cw_sel = SELW'(cfg_sel);
    done = s & m_arm;
    e_svld = cfg_g && (&m_fresh);
    if (e_svld) begin
      e_sum = 0;
      for (int c = 0; c < NCH; c++) e_sum += m_code[c];
    end
    m_fresh = cfg_g ? (((&m_fresh) ? '0 : m_fresh) | done) : '0;
    for (int c = 0; c < NCH; c++) begin
      if (done[c]) m_code[c] = (P - m_ref[c]) % range_now();
      e_vld[c] = done[c] && !cfg_g;
      if (done[c]) m_arm[c] = 0;
      if (r[c]) begin m_arm[c] = 1; m_ref[c] = P; end
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin m_ref[c] = 0; m_code[c] = 0; end
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    tag = "R1";
    chk("R1 code", int'(code), 0);
    chk("R1 vld", int'(code_vld), 0);
    chk("R1 sum", int'(sum_code), 0);
    chk("R1 svld", int'(sum_vld), 0);

    // R2 / R3: unit-step walk, every interval 1..25
    cfg_sel = 4;
    for (int d = 1; d <= 25; d++) begin
      tag = (d < NPH) ? "R2" : "R3";
      cyc(1, 3'b001, 3'b000, 0);
      for (int j = 1; j < d; j++) cyc(1, 0, 0, 0);
      cyc(1, 0, 3'b001, 0);
    end

    // R5: events on the wrap edge
    tag = "R5";
    while (P % NPH != 8) cyc(1, 0, 0, 0);
    cyc(4, 3'b010, 0, 0);
    cyc(3, 0, 0, 0);
    cyc(6, 0, 3'b010, 0);
    cyc(9, 3'b100, 0, 0);
    cyc(9, 0, 3'b100, 0);

    // R6: every width setting with a long interval
    tag = "R6";
    for (int sel = 0; sel < 8; sel++) begin
      cfg_sel = sel;
      cyc(7, 3'b001, 0, 0);
      for (int j = 0; j < 200; j++) cyc(9, 0, 0, 0);
      cyc(5, 0, 3'b001, 0);
    end

    // R7: counter rollover inside interval
    tag = "R7";
    cfg_sel = 4;
    cyc(3, 3'b010, 0, 0);
    for (int j = 0; j < 300; j++) cyc(9, 0, 0, 0);
    cyc(2, 0, 3'b010, 0);

    // R8: unarmed and repeated signal strobes
    tag = "R8";
    cyc(1, 0, 3'b100, 0);
    cyc(1, 0, 3'b100, 0);
    cyc(1, 3'b100, 0, 0);
    cyc(2, 0, 3'b100, 0);
    cyc(2, 0, 3'b100, 0);
    cyc(1, 0, 0, 0);

    // R9: re-reference and same-edge strobes
    tag = "R9";
    cyc(1, 3'b001, 0, 0);
    cyc(6, 0, 0, 0);
    cyc(3, 3'b001, 0, 0);
    cyc(4, 0, 3'b001, 0);
    cyc(2, 3'b001, 0, 0);
    cyc(5, 3'b001, 3'b001, 0);
    cyc(7, 0, 3'b001, 0);
    cyc(1, 0, 0, 0);

    // R10: swapped-bit snapshots
    tag = "R10";
    for (int d = 1; d <= 12; d++) begin
      cyc(1, 3'b010, 0, 1);
      for (int j = 0; j < d; j++) cyc(1, 0, 0, 1);
      cyc(1, 0, 3'b010, 1);
    end

    // R11: gang mode
    tag = "R11";
    cfg_g = 1;
    cyc(1, 3'b111, 0, 0);
    cyc(3, 0, 3'b001, 0);
    cyc(4, 0, 3'b010, 0);
    cyc(5, 0, 0, 0);
    cyc(6, 0, 3'b100, 0);
    cyc(1, 0, 0, 0);
    cyc(1, 3'b111, 0, 0);
    cyc(8, 0, 3'b111, 0);
    cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 0);
    cfg_g = 0;
    cyc(1, 0, 0, 0);

    // R12: concurrent channels
    tag = "R12";
    cyc(2, 3'b111, 0, 0);
    cyc(7, 0, 3'b100, 0);
    cyc(7, 0, 3'b011, 0);
    cyc(3, 3'b101, 3'b000, 0);
    cyc(9, 3'b010, 3'b101, 0);
    cyc(4, 0, 3'b010, 0);
    cyc(1, 0, 0, 0);

    // R4: random mix
    tag = "R4";
    for (int n = 0; n < 4000; n++) begin
      bit [NCH-1:0] r, s;
      if (n % 250 == 0) cfg_sel = int'($urandom_range(0, 7));
      if (n % 400 == 0) cfg_g = ($urandom_range(0, 2) == 0);
      for (int c = 0; c < NCH; c++) begin
        r[c] = ($urandom_range(0, 9) == 0);
        s[c] = ($urandom_range(0, 5) == 0);
      end
      cyc(int'($urandom_range(0, NPH - 1)), r, s, ($urandom_range(0, 3) == 0));
    end
    cfg_g = 0;
    cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 0);
    finish_run();
  end
endmodule